// File: doc/BRIEF.md
# Egress Ones-Complement Checksum Inserter

This block sits on the transmit side of a packet path. Each outgoing packet arrives as a byte stream on a valid/ready interface with start and end markers. A per-packet command sideband, sampled on the first byte, tells the block which bytes to cover and where to write the result. For every command it receives:

- a start offset,
- a byte count,
- a 16-bit seed, which the caller uses to fold in pseudo-header words it has already summed,
- an insert offset.

The block never parses protocol fields. The covered range comes entirely from the command.

The block stores the whole packet. While the bytes arrive it forms the 16-bit ones-complement sum of each command's range. It then replays the packet with the two result bytes written in at each insert offset. Up to `NCMD` commands (two by default) run side by side on the same packet. If any enabled command names a range or an insert position past the end of the packet, the packet is replayed untouched and a per-command error flag is raised.

Top module: `csum_insert`

## Requirements
- R1: The command fields are sampled only on the accepted byte that carries `in_sop`, and apply to that packet. Offsets count from 0 at that byte. Command values on later bytes have no effect.
- R2: Covered bytes are paired big-endian. The byte at an even distance from the start offset is the upper half of a 16-bit word, and the byte after it is the lower half.
- R3: When the byte count is odd, the last covered byte forms a word with 0x00 as its low byte.
- R4: The seed is part of the sum. Every carry out of bit 15 is added back into bit 0 (end-around carry).
- R5: The value inserted is the bitwise inverse of the folded sum. A result of 0x0000 is sent as 0xFFFF.
- R6: The high result byte replaces the byte at the insert offset and the low byte replaces the byte at insert offset + 1. All other bytes leave unchanged. Sums are taken over the bytes as received.
- R7: The commands are computed independently over the received bytes. If two commands write the same byte, the higher-numbered command's value is sent.
- R8: For an enabled command i, the range is out of bounds when start + count exceeds the packet length, or when insert + 2 exceeds it. If any enabled command is out of bounds, the whole packet is sent unmodified. Bit i of `out_err` is then 1 on every output byte of that packet. Otherwise `out_err` is 0.
- R9: The block stores and then forwards. `in_ready` is low while a packet is replayed. The first output byte, with `out_sop`, is valid in the cycle after the input byte with `in_eop` is accepted. `out_eop` marks the last byte. `in_ready` returns high after that byte is taken.
- R10: While `out_ready` is low, `out_valid`, `out_data`, `out_sop`, `out_eop` and `out_err` hold their values.
- R11: A command whose `cmd_en` bit is 0 patches nothing and raises no error, whatever its other fields hold.
- R12: After reset, `in_ready` is 1, `out_valid` is 0 and `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| cmd_en | input | NCMD | Per-command enable, sampled with in_sop |
| cmd_start | input | NCMD*OFS_W | Per-command first covered byte offset |
| cmd_len | input | NCMD*OFS_W | Per-command covered byte count |
| cmd_seed | input | NCMD*16 | Per-command initial sum |
| cmd_ins | input | NCMD*OFS_W | Per-command offset of the result's high byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte, patched |
| out_sop | output | 1 | First output byte |
| out_eop | output | 1 | Last output byte |
| out_err | output | NCMD | Per-command range error for the packet being replayed |

## Verification
The main function is driven with byte patterns generated by different multiplier and offset rules. These are combined with even and odd counts, ranges that start mid-packet, a full-packet range, and a zero-length range. Comparing them separates correct word pairing and odd padding from swapped or missing pad bytes.

Short hand-worked packets isolate further faults:
- one whose sum carries out of bit 15, which exposes a missing end-around carry;
- one whose folded sum is 0xFFFF, which exposes a missing zero-to-0xFFFF rule;
- one with a lone odd byte, which exposes wrong padding.

Packets where two commands overlap, or where a command is out of bounds or disabled, show whether precedence, whole-packet suppression and enable gating behave, with backpressure applied during some replays.

// File: rtl/csum_pkg.sv
`timescale 1ns/1ps
package csum_pkg;

    typedef enum logic {
        ST_RECV = 1'b0,
        ST_SEND = 1'b1
    } ins_state_e;

    typedef struct packed {
        logic [15:0] acc;
        logic [7:0]  hi;
    } acc_t;

    // ones-complement add with a single end-around fold
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    function automatic logic [15:0] oc_final(input logic [15:0] acc);
        logic [15:0] r;
        r = ~acc;
        return (r == 16'h0000) ? 16'hFFFF : r;
    endfunction

endpackage

// File: rtl/csum_accum.sv
`timescale 1ns/1ps
module csum_accum
    import csum_pkg::*;
#(
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             first,
    input  logic [OFS_W-1:0] pos,
    input  logic [7:0]       data,
    input  logic [OFS_W-1:0] start,
    input  logic [OFS_W-1:0] len,
    input  logic [15:0]      seed,
    output logic [15:0]      sum
);

    acc_t             acc_d, acc_q;
    logic [OFS_W:0]   pos_x, beg_x, end_x;
    logic [OFS_W-1:0] rel;
    logic             in_rng;
    logic [15:0]      base;

    always_comb begin
        acc_d  = acc_q;
        pos_x  = {1'b0, pos};
        beg_x  = {1'b0, start};
        end_x  = beg_x + {1'b0, len};
        in_rng = (pos_x >= beg_x) && (pos_x < end_x);
        rel    = pos - start;
        base   = first ? seed : acc_q.acc;
        if (beat) begin
            acc_d.acc = base;
            if (in_rng) begin
                if (rel[0]) begin
                    acc_d.acc = oc_add(base, {acc_q.hi, data});
                end else if (rel == len - 1'b1) begin
                    acc_d.acc = oc_add(base, {data, 8'h00});
                end else begin
                    acc_d.hi = data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum = acc_q.acc;

endmodule

// File: rtl/csum_pkt_buf.sv
`timescale 1ns/1ps
module csum_pkt_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/csum_insert.sv
`timescale 1ns/1ps
module csum_insert
    import csum_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int NCMD      = 2,
    parameter int OFS_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [7:0]            in_data,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [NCMD-1:0]       cmd_en,
    input  logic [NCMD*OFS_W-1:0] cmd_start,
    input  logic [NCMD*OFS_W-1:0] cmd_len,
    input  logic [NCMD*16-1:0]    cmd_seed,
    input  logic [NCMD*OFS_W-1:0] cmd_ins,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [7:0]            out_data,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic [NCMD-1:0]       out_err
);

    localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam logic [OFS_W:0] INS_SPAN = (OFS_W+1)'(2);
    localparam logic [OFS_W-1:0] CAP = OFS_W'(MAX_BYTES);

    typedef struct packed {
        ins_state_e                  st;
        logic [OFS_W-1:0]            cnt;
        logic [OFS_W-1:0]            plen;
        logic [OFS_W-1:0]            rd;
        logic [NCMD-1:0]             en;
        logic [NCMD-1:0][OFS_W-1:0]  start;
        logic [NCMD-1:0][OFS_W-1:0]  len;
        logic [NCMD-1:0][OFS_W-1:0]  ins;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCMD-1:0][OFS_W-1:0] in_start, in_len, in_ins;
    logic [NCMD-1:0][OFS_W-1:0] act_start, act_len;
    logic [NCMD-1:0][15:0]      in_seed, sum_w, res_w;
    logic [NCMD-1:0]            err_w;
    logic                       beat, first, patch_ok;
    logic [OFS_W-1:0]           pos;
    logic [7:0]                 buf_rdata;

    assign beat  = in_valid && in_ready;
    assign first = beat && in_sop;
    assign pos   = in_sop ? '0 : ctl_q.cnt;

    // one accumulator per command, fed by sideband at sop and held fields after
    for (genvar gi = 0; gi < NCMD; gi++) begin : g_cmd
        assign in_start[gi]  = cmd_start[gi*OFS_W +: OFS_W];
        assign in_len[gi]    = cmd_len[gi*OFS_W +: OFS_W];
        assign in_ins[gi]    = cmd_ins[gi*OFS_W +: OFS_W];
        assign in_seed[gi]   = cmd_seed[gi*16 +: 16];
        assign act_start[gi] = first ? in_start[gi] : ctl_q.start[gi];
        assign act_len[gi]   = first ? in_len[gi]   : ctl_q.len[gi];

        csum_accum #(.OFS_W(OFS_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .beat  (beat),
            .first (first),
            .pos   (pos),
            .data  (in_data),
            .start (act_start[gi]),
            .len   (act_len[gi]),
            .seed  (in_seed[gi]),
            .sum   (sum_w[gi])
        );

        assign res_w[gi] = oc_final(sum_w[gi]);
        assign err_w[gi] = ctl_q.en[gi] &&
            ((({1'b0, ctl_q.start[gi]} + {1'b0, ctl_q.len[gi]}) > {1'b0, ctl_q.plen}) ||
             (({1'b0, ctl_q.ins[gi]} + INS_SPAN) > {1'b0, ctl_q.plen}));
    end

    assign patch_ok = ~|err_w;

    csum_pkt_buf #(.DEPTH(MAX_BYTES), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (beat && (pos < CAP)),
        .waddr (pos[AW-1:0]),
        .wdata (in_data),
        .raddr (ctl_q.rd[AW-1:0]),
        .rdata (buf_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        in_ready  = (ctl_q.st == ST_RECV);
        out_valid = (ctl_q.st == ST_SEND);
        out_sop   = out_valid && (ctl_q.rd == '0);
        out_eop   = out_valid && (ctl_q.rd == ctl_q.plen - 1'b1);
        out_err   = out_valid ? err_w : '0;
        out_data  = buf_rdata;
        // later commands override earlier ones on shared bytes
        for (int i = 0; i < NCMD; i++) begin
            if (patch_ok && ctl_q.en[i]) begin
                if (ctl_q.rd == ctl_q.ins[i]) begin
                    out_data = res_w[i][15:8];
                end else if ({1'b0, ctl_q.rd} == ({1'b0, ctl_q.ins[i]} + 1'b1)) begin
                    out_data = res_w[i][7:0];
                end
            end
        end

        case (ctl_q.st)
            ST_RECV: begin
                if (beat) begin
                    ctl_d.cnt = pos + 1'b1;
                    if (in_sop) begin
                        ctl_d.en    = cmd_en;
                        ctl_d.start = in_start;
                        ctl_d.len   = in_len;
                        ctl_d.ins   = in_ins;
                    end
                    if (in_eop) begin
                        ctl_d.plen = pos + 1'b1;
                        ctl_d.rd   = '0;
                        ctl_d.st   = ST_SEND;
                    end
                end
            end
            default: begin
                if (out_ready) begin
                    ctl_d.rd = ctl_q.rd + 1'b1;
                    if (out_eop) ctl_d.st = ST_RECV;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/csum_insert_chk.sv
`timescale 1ns/1ps
module csum_insert_chk #(
    parameter int NCMD = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_eop,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_data,
    input logic            out_sop,
    input logic            out_eop,
    input logic [NCMD-1:0] out_err
);

    AST_REPLAY_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eop) |=> (out_valid && out_sop && !in_ready)); // R9

    AST_NO_INTAKE_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9

    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid); // R9

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                       && $stable(out_eop) && $stable(out_err))); // R10

    AST_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_eop)) |=> $stable(out_err)); // R8

    AST_ERR_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_err == '0)); // R8

endmodule

bind csum_insert csum_insert_chk #(.NCMD(NCMD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err)
);

// File: tb/csum_insert_tb.sv
`timescale 1ns/1ps
module csum_insert_tb;

    localparam int MAXB = 64;
    localparam int NC   = 2;
    localparam int OW   = 7;
    localparam int NV   = 8;

    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic            in_valid, in_ready, in_sop, in_eop;
    logic [7:0]      in_data;
    logic [NC-1:0]   cmd_en;
    logic [NC*OW-1:0] cmd_start, cmd_len, cmd_ins;
    logic [NC*16-1:0] cmd_seed;
    logic            out_valid, out_ready, out_sop, out_eop;
    logic [7:0]      out_data;
    logic [NC-1:0]   out_err;

    csum_insert #(.MAX_BYTES(MAXB), .NCMD(NC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .cmd_en(cmd_en), .cmd_start(cmd_start), .cmd_len(cmd_len),
        .cmd_seed(cmd_seed), .cmd_ins(cmd_ins),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  tx [MAXB];
    logic [7:0]  ex [MAXB];
    logic [NC-1:0] c_en;
    int          c_st [NC];
    int          c_ln [NC];
    int          c_in [NC];
    logic [15:0] c_sd [NC];

    typedef struct packed {
        int          len;
        int          mul;
        int          add;
        logic [1:0]  en;
        int          s0; int l0; int i0; logic [15:0] d0;
        int          s1; int l1; int i1; logic [15:0] d1;
        logic [1:0]  err;
        logic        bp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{20,  7,   3, 2'b01,  4, 10,  0, 16'h1234,  0,  0,  0, 16'h0000, 2'b00, 1'b0},
        '{33, 13, 200, 2'b11,  2, 21, 30, 16'h0000,  0, 33, 10, 16'hABCD, 2'b00, 1'b1},
        '{16,  5,   1, 2'b11, 10,  8,  0, 16'h0011,  0,  4,  4, 16'h0000, 2'b01, 1'b0},
        '{ 8,  3,   9, 2'b01,  0,  8,  7, 16'h0000,  0,  0,  0, 16'h0000, 2'b01, 1'b0},
        '{64,  1,   0, 2'b11,  0, 64, 62, 16'hFFFF,  1, 63, 62, 16'h0000, 2'b00, 1'b1},
        '{12, 11,  77, 2'b10, 50, 50, 40, 16'h5555,  3,  5,  0, 16'h0000, 2'b00, 1'b0},
        '{ 2, 17,   4, 2'b01,  0,  0,  0, 16'h0000,  0,  0,  0, 16'h0000, 2'b00, 1'b0},
        '{10, 29,  31, 2'b11,  0,  4,  8, 16'h0F0F,  5,  6,  0, 16'h0000, 2'b10, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // reference: wide accumulate, then fold until no carry remains
    function automatic logic [15:0] ref_sum(input int st, input int ln, input logic [15:0] sd);
        int unsigned s;
        logic [15:0] r;
        s = sd;
        for (int k = 0; k < ln; k++) begin
            if ((k % 2) == 0) s += {tx[st+k], 8'h00};
            else              s += tx[st+k];
        end
        while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
        r = ~s[15:0];
        return (r == 16'h0000) ? 16'hFFFF : r;
    endfunction

    task automatic build_exp(input int len, input logic [1:0] errx);
        logic [15:0] r;
        for (int k = 0; k < len; k++) ex[k] = tx[k];
        if (errx == 2'b00) begin
            for (int i = 0; i < NC; i++) begin
                if (c_en[i]) begin
                    r = ref_sum(c_st[i], c_ln[i], c_sd[i]);
                    ex[c_in[i]]   = r[15:8];
                    ex[c_in[i]+1] = r[7:0];
                end
            end
        end
    endtask

    // R1: commands driven for real only with the sop byte, junk afterwards
    task automatic send(input int len);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_data  = tx[k];
            in_sop   = (k == 0);
            in_eop   = (k == len - 1);
            for (int i = 0; i < NC; i++) begin
                if (k == 0) begin
                    cmd_en[i]              = c_en[i];
                    cmd_start[i*OW +: OW]  = OW'(c_st[i]);
                    cmd_len[i*OW +: OW]    = OW'(c_ln[i]);
                    cmd_ins[i*OW +: OW]    = OW'(c_in[i]);
                    cmd_seed[i*16 +: 16]   = c_sd[i];
                end else begin
                    cmd_en[i]              = ~c_en[i];
                    cmd_start[i*OW +: OW]  = OW'(k + 1);
                    cmd_len[i*OW +: OW]    = OW'(3);
                    cmd_ins[i*OW +: OW]    = OW'(k);
                    cmd_seed[i*16 +: 16]   = 16'hDEAD;
                end
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        chk("R9", "out_valid after eop", int'(out_valid), 1);
        chk("R9", "out_sop after eop", int'(out_sop), 1);
        chk("R9", "in_ready in replay", int'(in_ready), 0);
    endtask

    task automatic recv(input int len, input bit bp, input logic [1:0] errx, input string req);
        logic [7:0] held;
        for (int k = 0; k < len; k++) begin
            if (bp && (k % 3 == 1)) begin
                out_ready = 1'b0;
                held = out_data;
                @(negedge clk);
                chk("R10", "data held under stall", int'(out_data), int'(held));
                chk("R10", "valid held under stall", int'(out_valid), 1);
                out_ready = 1'b1;
            end
            chk(req, $sformatf("byte %0d", k), int'(out_data), int'(ex[k]));
            chk("R9", "out_eop position", int'(out_eop), int'(k == len - 1));
            chk("R8", "out_err", int'(out_err), int'(errx));
            @(negedge clk);
        end
        chk("R9", "in_ready after replay", int'(in_ready), 1);
        chk("R9", "out_valid after replay", int'(out_valid), 0);
    endtask

    task automatic one_cmd(input int st, input int ln, input int ins, input logic [15:0] sd);
        c_en = 2'b01;
        c_st[0] = st; c_ln[0] = ln; c_in[0] = ins; c_sd[0] = sd;
        c_st[1] = 0;  c_ln[1] = 0;  c_in[1] = 0;   c_sd[1] = 16'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        cmd_en = '0; cmd_start = '0; cmd_len = '0; cmd_ins = '0; cmd_seed = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12", "in_ready", int'(in_ready), 1);
        chk("R12", "out_valid", int'(out_valid), 0);
        chk("R12", "out_err", int'(out_err), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < VECS[v].len; k++) tx[k] = 8'(k * VECS[v].mul + VECS[v].add);
            c_en = VECS[v].en;
            c_st[0] = VECS[v].s0; c_ln[0] = VECS[v].l0; c_in[0] = VECS[v].i0; c_sd[0] = VECS[v].d0;
            c_st[1] = VECS[v].s1; c_ln[1] = VECS[v].l1; c_in[1] = VECS[v].i1; c_sd[1] = VECS[v].d1;
            build_exp(VECS[v].len, VECS[v].err);
            send(VECS[v].len);
            recv(VECS[v].len, VECS[v].bp, VECS[v].err,
                 (VECS[v].err != 0) ? "R8 unmodified" : "R1 R6 R7 R11 patched");
        end

        // R2 pairing: 12 34 -> sum 1234, inverse EDCB
        tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'h00; tx[3] = 8'h00;
        one_cmd(0, 2, 2, 16'h0000);
        ex[0] = 8'h12; ex[1] = 8'h34; ex[2] = 8'hED; ex[3] = 8'hCB;
        send(4); recv(4, 1'b0, 2'b00, "R2 big-endian");

        // R3 odd count: 0102 + 0300 = 0402 -> FBFD
        tx[0] = 8'h01; tx[1] = 8'h02; tx[2] = 8'h03; tx[3] = 8'h00; tx[4] = 8'h00;
        one_cmd(0, 3, 3, 16'h0000);
        ex[0] = 8'h01; ex[1] = 8'h02; ex[2] = 8'h03; ex[3] = 8'hFB; ex[4] = 8'hFD;
        send(5); recv(5, 1'b0, 2'b00, "R3 odd pad");

        // R4 end-around: FFFF + 0001 -> 0001 -> FFFE
        tx[0] = 8'h00; tx[1] = 8'h01; tx[2] = 8'h00; tx[3] = 8'h00;
        one_cmd(0, 2, 2, 16'hFFFF);
        ex[0] = 8'h00; ex[1] = 8'h01; ex[2] = 8'hFF; ex[3] = 8'hFE;
        send(4); recv(4, 1'b0, 2'b00, "R4 fold");

        // R5 zero result sent as FFFF: seed FFFF, empty range
        tx[0] = 8'h5A; tx[1] = 8'hA5; tx[2] = 8'h00;
        one_cmd(0, 0, 0, 16'hFFFF);
        ex[0] = 8'hFF; ex[1] = 8'hFF; ex[2] = 8'h00;
        send(3); recv(3, 1'b0, 2'b00, "R5 zero rule");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule